// File: doc/BRIEF.md
# Two-level indirect branch target predictor

This block supplies predicted targets for indirect branches from two direct-mapped, tagged tables. The first table is indexed by the branch address alone and keeps one target per branch, together with a flag saying whether the branch was last resolved as indirect. The second table is indexed by the low address bits XORed with a global history of recent branch outcomes. It can therefore hold several targets for one branch, one for each history context.

A fetch address presented on the lookup port yields a hit flag, a target and a flag showing which table supplied it. The history-indexed table only supplies the answer when the per-address entry hits, is flagged indirect, and the history-indexed entry also hits. A branch earns a history-indexed entry only after its per-address entry has predicted the wrong target. A branch that always goes to one place never occupies the second table.

Each resolved branch is reported on the resolve port with its address, its actual target, its kind and the history snapshot it was predicted under. The resolve updates both tables and shifts the global history.

Top module: `itp_top`

## Requirements
- R1: After reset every entry of both tables is invalid, so any lookup returns lk_hit=0, lk_target=0 and lk_use_hist=0, and ghist reads 0.
- R2: The per-address table is indexed by pc[BASE_IDX_W-1:0] and tagged with the remaining upper pc bits. Every valid resolve writes that entry with valid=1, the actual target and the rs_indirect flag, replacing any other branch that shared the index. A lookup that misses drives lk_target=0.
- R3: An indirect branch resolved for the first time (per-address miss) is written only into the per-address table; a later lookup of it returns the per-address target with lk_use_hist=0.
- R4: When an indirect branch resolves and its per-address entry hits with a target different from the actual one, the history-indexed entry at index pc[GH_W-1:0] XOR rs_hist (tag pc[ADDR_W-1:GH_W]) is written with the actual target.
- R5: lk_use_hist=1 and lk_target equals the history-indexed target exactly when the per-address entry hits, has its indirect flag set, and the history-indexed entry at pc[GH_W-1:0] XOR ghist hits; otherwise lk_target is the per-address target.
- R6: A resolve with rs_indirect=0 never writes the history-indexed table, and it clears the per-address indirect flag so that branch is never predicted from the second table.
- R7: An indirect branch whose per-address entry always predicts the actual target never gains a history-indexed entry.
- R8: An indirect resolve whose history-indexed entry (at the snapshot context) already hits retrains that entry with the actual target.
- R9: On every valid resolve ghist shifts left by one and takes rs_target[0] into bit 0; with rs_valid=0 it holds.
- R10: A lookup in the same cycle as a resolve that updates the looked-up entries or the history sees the contents and history from before that resolve.
- R11: One branch may hold several history-indexed entries for different contexts, and each is returned when ghist matches its context.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| lk_pc | input | ADDR_W | Fetch address to predict |
| lk_hit | output | 1 | Per-address entry for lk_pc is present |
| lk_target | output | ADDR_W | Predicted target, 0 on a miss |
| lk_use_hist | output | 1 | Target came from the history-indexed table |
| rs_valid | input | 1 | A branch resolves this cycle |
| rs_pc | input | ADDR_W | Address of the resolving branch |
| rs_target | input | ADDR_W | Actual target of the resolving branch |
| rs_indirect | input | 1 | Resolving branch is indirect |
| rs_hist | input | GH_W | History snapshot used when the branch was predicted |
| ghist | output | GH_W | Current global history |

## Verification
The directed part builds the case that breaks most implementations: one branch with two history contexts that point to different targets. The same branch is then taken back to each context, so a design that indexes with the wrong history or allocates on the first sighting returns the wrong target or raises lk_use_hist too early. Other directed cases check the following. A single-target indirect branch must never switch to the second table, which would show up as lk_use_hist=1. A branch resolved as direct must keep lk_use_hist low. A tag collision in the per-address table must evict the older branch so that its lookup misses. A lookup must see old contents in the cycle of a resolve that retrains the entry it reads, so a write-through design would show the new target one cycle early. Random traffic over a small set of colliding addresses is compared every cycle against a bench model of both tables and the history.

// File: rtl/itp_pkg.sv
package itp_pkg;
  // Which table supplied the lookup answer
  typedef enum logic [1:0] {
    SRC_NONE = 2'd0,
    SRC_BASE = 2'd1,
    SRC_HIST = 2'd2
  } pred_src_e;
endpackage

// File: rtl/itp_ghist.sv
module itp_ghist #(
  parameter int GH_W = 8
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            shift_en,
  input  logic            shift_bit,
  output logic [GH_W-1:0] gh
);
  function automatic logic [GH_W-1:0] gh_next(input logic [GH_W-1:0] cur, input logic b);
    return {cur[GH_W-2:0], b};
  endfunction

  always_ff @(posedge clk) begin
    if (!rst_n)        gh <= '0;
    else if (shift_en) gh <= gh_next(gh, shift_bit);
  end

  // R9: one position per resolve, newest bit at the bottom
  p_gh_shift_r9: assert property (@(posedge clk) disable iff (!rst_n)
    shift_en |=> gh == {$past(gh[GH_W-2:0]), $past(shift_bit)});
  // R9: no resolve, no change
  p_gh_hold_r9: assert property (@(posedge clk) disable iff (!rst_n)
    !shift_en |=> $stable(gh));
endmodule

// File: rtl/itp_base_tbl.sv
module itp_base_tbl #(
  parameter int ADDR_W = 32,
  parameter int IDX_W  = 6
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [ADDR_W-1:0] lk_pc,
  output logic              lk_hit,
  output logic [ADDR_W-1:0] lk_tgt,
  output logic              lk_ind,
  input  logic [ADDR_W-1:0] rs_pc,
  output logic              rs_hit,
  output logic [ADDR_W-1:0] rs_tgt,
  input  logic              wr_en,
  input  logic [ADDR_W-1:0] wr_tgt,
  input  logic              wr_ind
);
  localparam int DEPTH = 1 << IDX_W;
  localparam int TAG_W = ADDR_W - IDX_W;

  function automatic logic [IDX_W-1:0] idx_of(input logic [ADDR_W-1:0] pc);
    return pc[IDX_W-1:0];
  endfunction
  function automatic logic [TAG_W-1:0] tag_of(input logic [ADDR_W-1:0] pc);
    return pc[ADDR_W-1:IDX_W];
  endfunction

  logic [DEPTH-1:0]  vld_q;
  logic [DEPTH-1:0]  ind_q;
  logic [TAG_W-1:0]  tag_q [DEPTH];
  logic [ADDR_W-1:0] tgt_q [DEPTH];

  logic [IDX_W-1:0] lk_idx, rs_idx;
  assign lk_idx = idx_of(lk_pc);
  assign rs_idx = idx_of(rs_pc);

  // Reads see the stored state, so a same-cycle write is not visible (R10)
  assign lk_hit = vld_q[lk_idx] && (tag_q[lk_idx] == tag_of(lk_pc));
  assign lk_tgt = tgt_q[lk_idx];
  assign lk_ind = ind_q[lk_idx];
  assign rs_hit = vld_q[rs_idx] && (tag_q[rs_idx] == tag_of(rs_pc));
  assign rs_tgt = tgt_q[rs_idx];

  always_ff @(posedge clk) begin
    if (!rst_n)     vld_q <= '0;
    else if (wr_en) vld_q[rs_idx] <= 1'b1;
  end

  always_ff @(posedge clk) begin
    if (wr_en) begin
      tag_q[rs_idx] <= tag_of(rs_pc);
      tgt_q[rs_idx] <= wr_tgt;
      ind_q[rs_idx] <= wr_ind;
    end
  end

  // R2: a written slot is valid afterwards
  p_wr_valid_r2: assert property (@(posedge clk) disable iff (!rst_n)
    wr_en |=> vld_q[$past(rs_idx)]);
endmodule

// File: rtl/itp_hist_tbl.sv
module itp_hist_tbl #(
  parameter int ADDR_W = 32,
  parameter int GH_W   = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [ADDR_W-1:0] lk_pc,
  input  logic [GH_W-1:0]   lk_gh,
  output logic              lk_hit,
  output logic [ADDR_W-1:0] lk_tgt,
  input  logic [ADDR_W-1:0] rs_pc,
  input  logic [GH_W-1:0]   rs_gh,
  output logic              rs_hit,
  input  logic              wr_en,
  input  logic [ADDR_W-1:0] wr_tgt
);
  localparam int DEPTH = 1 << GH_W;
  localparam int TAG_W = ADDR_W - GH_W;
  localparam int NPORT = 2;

  function automatic logic [GH_W-1:0] hidx(input logic [ADDR_W-1:0] pc, input logic [GH_W-1:0] h);
    return pc[GH_W-1:0] ^ h;
  endfunction
  function automatic logic [TAG_W-1:0] htag(input logic [ADDR_W-1:0] pc);
    return pc[ADDR_W-1:GH_W];
  endfunction

  logic [DEPTH-1:0]  vld_q;
  logic [TAG_W-1:0]  tag_q [DEPTH];
  logic [ADDR_W-1:0] tgt_q [DEPTH];

  logic [ADDR_W-1:0] p_pc  [NPORT];
  logic [GH_W-1:0]   p_gh  [NPORT];
  logic [NPORT-1:0]  p_hit;
  logic [ADDR_W-1:0] p_tgt [NPORT];

  assign p_pc[0] = lk_pc;
  assign p_gh[0] = lk_gh;
  assign p_pc[1] = rs_pc;
  assign p_gh[1] = rs_gh;

  for (genvar p = 0; p < NPORT; p++) begin : g_rd
    logic [GH_W-1:0] ix;
    assign ix       = hidx(p_pc[p], p_gh[p]);
    assign p_hit[p] = vld_q[ix] && (tag_q[ix] == htag(p_pc[p]));
    assign p_tgt[p] = tgt_q[ix];
  end

  assign lk_hit = p_hit[0];
  assign lk_tgt = p_tgt[0];
  assign rs_hit = p_hit[1];

  logic [GH_W-1:0] wr_idx;
  assign wr_idx = hidx(rs_pc, rs_gh);

  always_ff @(posedge clk) begin
    if (!rst_n)     vld_q <= '0;
    else if (wr_en) vld_q[wr_idx] <= 1'b1;
  end

  always_ff @(posedge clk) begin
    if (wr_en) begin
      tag_q[wr_idx] <= htag(rs_pc);
      tgt_q[wr_idx] <= wr_tgt;
    end
  end

  // R4: a written context is valid afterwards
  p_wr_valid_r4: assert property (@(posedge clk) disable iff (!rst_n)
    wr_en |=> vld_q[$past(wr_idx)]);
endmodule

// File: rtl/itp_top.sv
module itp_top #(
  parameter int ADDR_W     = 32,
  parameter int BASE_IDX_W = 6,
  parameter int GH_W       = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [ADDR_W-1:0] lk_pc,
  output logic              lk_hit,
  output logic [ADDR_W-1:0] lk_target,
  output logic              lk_use_hist,
  input  logic              rs_valid,
  input  logic [ADDR_W-1:0] rs_pc,
  input  logic [ADDR_W-1:0] rs_target,
  input  logic              rs_indirect,
  input  logic [GH_W-1:0]   rs_hist,
  output logic [GH_W-1:0]   ghist
);
  import itp_pkg::*;

  // Named internal events
  logic              lk_base_hit, lk_base_ind, lk_hist_hit;
  logic [ADDR_W-1:0] lk_base_tgt, lk_hist_tgt;
  logic              rs_base_hit, rs_hist_hit;
  logic [ADDR_W-1:0] rs_base_tgt;
  logic              base_mispred, hist_alloc, hist_retrain, hist_we;
  pred_src_e         src;

  itp_base_tbl #(.ADDR_W(ADDR_W), .IDX_W(BASE_IDX_W)) u_base (
    .clk(clk), .rst_n(rst_n),
    .lk_pc(lk_pc), .lk_hit(lk_base_hit), .lk_tgt(lk_base_tgt), .lk_ind(lk_base_ind),
    .rs_pc(rs_pc), .rs_hit(rs_base_hit), .rs_tgt(rs_base_tgt),
    .wr_en(rs_valid), .wr_tgt(rs_target), .wr_ind(rs_indirect)
  );

  itp_hist_tbl #(.ADDR_W(ADDR_W), .GH_W(GH_W)) u_hist (
    .clk(clk), .rst_n(rst_n),
    .lk_pc(lk_pc), .lk_gh(ghist), .lk_hit(lk_hist_hit), .lk_tgt(lk_hist_tgt),
    .rs_pc(rs_pc), .rs_gh(rs_hist), .rs_hit(rs_hist_hit),
    .wr_en(hist_we), .wr_tgt(rs_target)
  );

  itp_ghist #(.GH_W(GH_W)) u_gh (
    .clk(clk), .rst_n(rst_n),
    .shift_en(rs_valid), .shift_bit(rs_target[0]), .gh(ghist)
  );

  // Allocation policy
  assign base_mispred = rs_base_hit && (rs_base_tgt != rs_target);
  assign hist_alloc   = rs_valid && rs_indirect && base_mispred;
  assign hist_retrain = rs_valid && rs_indirect && rs_hist_hit;
  assign hist_we      = hist_alloc || hist_retrain;

  // Selection
  always_comb begin
    if (!lk_base_hit)                    src = SRC_NONE;
    else if (lk_base_ind && lk_hist_hit) src = SRC_HIST;
    else                                 src = SRC_BASE;
  end

  always_comb begin
    lk_hit      = (src != SRC_NONE);
    lk_use_hist = (src == SRC_HIST);
    case (src)
      SRC_HIST: lk_target = lk_hist_tgt;
      SRC_BASE: lk_target = lk_base_tgt;
      default:  lk_target = '0;
    endcase
  end

  // R5: second table only behind an indirect per-address hit
  p_sel_gate_r5: assert property (@(posedge clk) disable iff (!rst_n)
    lk_use_hist |-> (lk_base_hit && lk_base_ind && lk_target == lk_hist_tgt));
  // R2: a miss drives a zero target
  p_miss_zero_r2: assert property (@(posedge clk) disable iff (!rst_n)
    !lk_hit |-> (lk_target == '0 && !lk_use_hist));
  // R6: only indirect resolves write the second table
  p_ind_only_r6: assert property (@(posedge clk) disable iff (!rst_n)
    hist_we |-> (rs_valid && rs_indirect));
  // R3: no second-table write for a branch never seen before in any table
  p_first_seen_r3: assert property (@(posedge clk) disable iff (!rst_n)
    hist_we |-> (rs_base_hit || rs_hist_hit));
  // R7: a correct per-address prediction with no context entry allocates nothing
  p_single_tgt_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (rs_valid && rs_base_hit && rs_base_tgt == rs_target && !rs_hist_hit) |-> !hist_we);
endmodule

// File: tb/test_itp_top.sv
module test_itp_top;
  localparam int AW = 32;
  localparam int BW = 6;
  localparam int GW = 8;
  localparam int BD = 64;
  localparam int HD = 256;
  localparam int NPC = 8;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic [AW-1:0] lk_pc = '0;
  logic          lk_hit;
  logic [AW-1:0] lk_target;
  logic          lk_use_hist;
  logic          rs_valid = 1'b0;
  logic [AW-1:0] rs_pc = '0;
  logic [AW-1:0] rs_target = '0;
  logic          rs_indirect = 1'b0;
  logic [GW-1:0] rs_hist = '0;
  logic [GW-1:0] ghist;

  int total = 0;
  int bad   = 0;
  bit done  = 0;

  always #2 clk = ~clk;

  itp_top #(.ADDR_W(AW), .BASE_IDX_W(BW), .GH_W(GW)) i_itp_top (
    .clk(clk), .rst_n(rst_n), .lk_pc(lk_pc), .lk_hit(lk_hit), .lk_target(lk_target),
    .lk_use_hist(lk_use_hist), .rs_valid(rs_valid), .rs_pc(rs_pc), .rs_target(rs_target),
    .rs_indirect(rs_indirect), .rs_hist(rs_hist), .ghist(ghist)
  );

  // Reference model
  bit            mbv [BD];
  logic [AW-1:0] mbtag [BD];
  logic [AW-1:0] mbtgt [BD];
  bit            mbind [BD];
  bit            mhv [HD];
  logic [AW-1:0] mhtag [HD];
  logic [AW-1:0] mhtgt [HD];
  logic [GW-1:0] m_gh = '0;

  function automatic int bslot(input logic [AW-1:0] pc);
    return int'(pc % BD);
  endfunction
  function automatic int hslot(input logic [AW-1:0] pc, input logic [GW-1:0] h);
    return int'((pc % HD) ^ AW'(h));
  endfunction

  task automatic m_look(input logic [AW-1:0] pc, output bit hit, output logic [AW-1:0] tgt, output bit uh);
    int b = bslot(pc);
    int h = hslot(pc, m_gh);
    bit bh = mbv[b] && (mbtag[b] == (pc >> BW));
    bit hh = mhv[h] && (mhtag[h] == (pc >> GW));
    hit = bh;
    uh  = bh && mbind[b] && hh;
    tgt = !bh ? '0 : (uh ? mhtgt[h] : mbtgt[b]);
  endtask

  task automatic m_resolve(input logic [AW-1:0] pc, input logic [AW-1:0] tgt, input bit ind, input logic [GW-1:0] snap);
    int b = bslot(pc);
    int h = hslot(pc, snap);
    bit bh  = mbv[b] && (mbtag[b] == (pc >> BW));
    bit mis = bh && (mbtgt[b] != tgt);
    bit hh  = mhv[h] && (mhtag[h] == (pc >> GW));
    if (ind && (mis || hh)) begin
      mhv[h] = 1; mhtag[h] = pc >> GW; mhtgt[h] = tgt;
    end
    mbv[b] = 1; mbtag[b] = pc >> BW; mbtgt[b] = tgt; mbind[b] = ind;
    m_gh = {m_gh[GW-2:0], tgt[0]};
  endtask

  task automatic check(input bit ok, input string req, input string what, input logic [AW-1:0] act, input logic [AW-1:0] exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s %s actual=%h expected=%h", req, what, act, exp);
    end
  endtask

  // One cycle: drive, check model (and optional directed expectation), clock, update model
  task automatic step(input logic [AW-1:0] lpc, input bit rv, input logic [AW-1:0] rpc,
                      input logic [AW-1:0] rtgt, input bit rind, input logic [GW-1:0] rh,
                      input bit dchk, input bit ehit, input logic [AW-1:0] etgt, input bit euh,
                      input int egh, input string req);
    bit mh, mu;
    logic [AW-1:0] mt;
    @(negedge clk);
    lk_pc = lpc; rs_valid = rv; rs_pc = rpc; rs_target = rtgt; rs_indirect = rind; rs_hist = rh;
    #1;
    m_look(lpc, mh, mt, mu);
    check(lk_hit == mh && lk_target == mt && lk_use_hist == mu, "R5", "model lookup hit/target/uh",
          {lk_target[AW-3:0], lk_hit, lk_use_hist}, {mt[AW-3:0], mh, mu});
    check(ghist == m_gh, "R9", "model ghist", AW'(ghist), AW'(m_gh));
    if (dchk) begin
      check(lk_hit == ehit, req, "lk_hit", AW'(lk_hit), AW'(ehit));
      check(lk_target == etgt, req, "lk_target", lk_target, etgt);
      check(lk_use_hist == euh, req, "lk_use_hist", AW'(lk_use_hist), AW'(euh));
    end
    if (egh >= 0) check(ghist == GW'(egh), req, "ghist", AW'(ghist), AW'(egh));
    @(posedge clk);
    if (rv) m_resolve(rpc, rtgt, rind, rh);
  endtask

  task automatic look(input logic [AW-1:0] pc, input bit ehit, input logic [AW-1:0] etgt,
                      input bit euh, input int egh, input string req);
    step(pc, 0, '0, '0, 0, '0, 1, ehit, etgt, euh, egh, req);
  endtask

  task automatic res(input logic [AW-1:0] pc, input logic [AW-1:0] tgt, input bit ind, input logic [GW-1:0] h);
    step(pc, 1, pc, tgt, ind, h, 0, 0, '0, 0, -1, "");
  endtask

  // Push a history pattern through a direct branch, oldest bit first
  task automatic push_hist(input logic [GW-1:0] pat);
    for (int i = GW - 1; i >= 0; i--) res(32'h0000_2200, 32'h0000_7000 | AW'(pat[i]), 0, m_gh);
  endtask

  function automatic logic [AW-1:0] pool_pc(input int i);
    case (i)
      0: return 32'h0000_1234;
      1: return 32'h4000_1234;
      2: return 32'h0000_2200;
      3: return 32'h0000_3318;
      4: return 32'h0000_0A35;
      5: return 32'h1000_0034;
      6: return 32'h0000_5678;
      default: return 32'h0000_9ABC;
    endcase
  endfunction
  function automatic bit pool_ind(input int i);
    return !(i == 2 || i == 5);
  endfunction
  function automatic bit pool_single(input int i);
    return (i == 3 || i == 6);
  endfunction

  localparam logic [AW-1:0] A  = 32'h0000_1234;
  localparam logic [AW-1:0] B  = 32'h0000_2200;
  localparam logic [AW-1:0] C  = 32'h0000_3318;
  localparam logic [AW-1:0] D  = 32'h4000_1234;
  localparam logic [AW-1:0] T1 = 32'h0000_5000;
  localparam logic [AW-1:0] T2 = 32'h0000_6001;
  localparam logic [AW-1:0] T3 = 32'h0000_9000;
  localparam logic [AW-1:0] T4 = 32'h0000_A000;

  initial begin
    #(4 * 150000);
    if (!done) begin
      total++; bad++;
      $display("FAIL watchdog expired actual=running expected=finished");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'd20240611));
    for (int i = 0; i < BD; i++) mbv[i] = 0;
    for (int i = 0; i < HD; i++) mhv[i] = 0;
    repeat (3) @(posedge clk);
    @(negedge clk) rst_n = 1'b1;

    // R1: empty after reset
    look(A, 0, '0, 0, 0, "R1");
    // R10: lookup while first resolve of A is written -> still a miss
    step(A, 1, A, T1, 1, 8'h00, 1, 0, '0, 0, 0, "R10");
    // R3: first sighting lives only in the per-address table
    step(A, 1, A, T2, 1, 8'h00, 1, 1, T1, 0, 0, "R3");
    // R4: second mispredict under context 0x55
    step(A, 1, A, T3, 1, 8'h55, 1, 1, T2, 0, 1, "R4");
    // R9: history after targets even, odd, even
    look(A, 1, T3, 0, 2, "R9");
    // R4 R5: back to context 0 -> history-indexed target
    push_hist(8'h00);
    look(A, 1, T2, 1, 0, "R4");
    // R6: direct branch never uses the second table
    look(B, 1, 32'h0000_7000, 0, 0, "R6");
    // R11: second context of the same branch
    push_hist(8'h55);
    look(A, 1, T3, 1, 8'h55, "R11");
    // R10: retraining write in the same cycle shows old contents
    step(A, 1, A, T4, 1, 8'h55, 1, 1, T3, 1, 8'h55, "R10");
    // R8: retrained context now returns the new target
    push_hist(8'h55);
    look(A, 1, T4, 1, 8'h55, "R8");
    // R7: single-target indirect branch under context 0
    res(C, 32'h0000_B000, 1, 8'h00);
    res(C, 32'h0000_B000, 1, 8'h00);
    res(C, 32'h0000_B000, 1, 8'h00);
    push_hist(8'h00);
    look(C, 1, 32'h0000_B000, 0, 0, "R7");
    // R2: index collision evicts the older branch
    res(D, 32'h0000_C000, 0, m_gh);
    look(A, 0, '0, 0, 0, "R2");
    look(D, 1, 32'h0000_C000, 0, 0, "R2");

    // Random traffic against the model (R5, R9 each cycle)
    for (int n = 0; n < 3000; n++) begin
      int li = int'($urandom % NPC);
      int ri = int'($urandom % NPC);
      bit rv = ($urandom % 10) < 6;
      int k  = pool_single(ri) ? 0 : int'($urandom % 4);
      logic [AW-1:0] tg = 32'h0010_0000 + AW'(ri << 8) + AW'(k);
      logic [GW-1:0] sn = (($urandom % 4) == 0) ? GW'($urandom) : m_gh;
      step(pool_pc(li), rv, pool_pc(ri), tg, pool_ind(ri), sn, 0, 0, '0, 0, -1, "");
    end

    done = 1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule